// File: doc/BRIEF.md
# Interlocked Multiplexed-Bus Read Link

This block moves read data between a bus master and a memory-side slave over one set of shared address/data lines. No step relies on fixed timing. Every transition waits for the partner's strobe and is then answered. Before it touches the lines, the master asks an arbiter for the bus and waits until the bus is granted. It then sends a single address word and collects one or more data words. For each data word the slave supplies the value and the master takes it, using a four-step exchange.

A client pulses `start` while the link is idle and gives a base word address and a length of 1 to 16 words. The link returns each word on `rd_data` with a one-cycle `rd_valid` pulse and its position in `rd_index`. It finishes with a one-cycle `done`. The slave serves a read-only word array. Every entry is loaded at reset with a computed pattern. Reads walk forward from the base address and wrap at the end of the array.

The shared lines, the strobes, the request and grant, and both drive enables are brought to the top-level ports so that the handshake can be watched.

Top module: `amux_read_link`

## Requirements
- R1: While reset is held and just after it, `busy`, `done`, `rd_valid`, `bus_req`, `bus_read`, `bus_addr_ack`, `bus_dready`, `bus_data_ack` and both drive enables are low.
- R2: `bus_read` is asserted only while `bus_gnt` is high. The grant follows `bus_req` by one cycle.
- R3: The address phase is a four-step exchange. `bus_read` rises while the master drives `bus_ad`. `bus_addr_ack` rises only while `bus_read` is high. `bus_read` falls only after `bus_addr_ack` is high. `bus_addr_ack` falls only after `bus_read` is low. The address word carries the length minus one in bits [15:12] and the base address in bits [5:0], with zeros elsewhere.
- R4: Each data word is a four-step exchange. `bus_dready` rises only while `bus_data_ack` is low. `bus_data_ack` rises only while `bus_dready` is high. `bus_dready` falls only after `bus_data_ack` is high. `bus_data_ack` falls only after `bus_dready` is low.
- R5: Each side drives `bus_ad` for at least SETUP cycles before the cycle in which it raises its strobe (`bus_read` for the master, `bus_dready` for the slave).
- R6: Word k of a transfer is (i*0x0123 + 0x3C5A) mod 2^16, where i = (base + k) mod 64. It appears on `bus_ad` when `bus_dready` rises, and it appears on `rd_data` with `rd_index` = k when `rd_valid` pulses.
- R7: A transfer with `start_len_m1` = n-1 delivers exactly n `rd_valid` pulses and uses exactly one address phase.
- R8: `done` is high for exactly one cycle, after the last `bus_data_ack` has fallen. `bus_req` is low in that cycle, and `busy` is low in the cycle after it.
- R9: A `start` pulse while `busy` is high is ignored. The transfer in progress keeps its address and length, and no second transfer follows.
- R10: `bus_m_oe` and `bus_s_oe` are never high together, and `bus_err` stays low.
- R11: A block that runs past the last array entry wraps to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| start_addr | input | 6 | Base word address |
| start_len_m1 | input | 4 | Word count minus one |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_valid | output | 1 | One-cycle pulse marking a received word |
| rd_data | output | 16 | Received word |
| rd_index | output | 4 | Position of the received word within the block |
| bus_req | output | 1 | Master bus request |
| bus_gnt | output | 1 | Arbiter grant |
| bus_ad | output | 16 | Shared address/data lines |
| bus_m_oe | output | 1 | Master drives the shared lines |
| bus_s_oe | output | 1 | Slave drives the shared lines |
| bus_read | output | 1 | Master address strobe |
| bus_addr_ack | output | 1 | Slave acknowledge of the address |
| bus_dready | output | 1 | Slave data strobe |
| bus_data_ack | output | 1 | Master acknowledge of a data word |
| bus_err | output | 1 | Both sides drive the shared lines at once |

## Verification
The bench covers every base address with every length from 1 to 16. This reaches the block that crosses the array end, where a slave that does not wrap its index would return wrong or stale words. A slave that released data before the master's acknowledge, or a master that dropped its acknowledge too early, would show up as an edge out of order on the strobe lines, or as a word counted twice or missed. Repeated `start` pulses in the middle of a transfer target a master that re-latches its address or length, which would corrupt the words or start an extra transfer. A length field decoded wrongly would show up as a wrong number of `rd_valid` pulses before `done`.

// File: rtl/amux_pkg.sv
package amux_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_REQ, M_ASET, M_ASTB, M_AREL, M_DWAIT, M_DACK, M_DONE
  } mst_state_t;

  typedef enum logic [2:0] {
    S_IDLE, S_AACK, S_DSET, S_DSTB, S_DREL
  } slv_state_t;

  // Reset pattern of array entry idx.
  function automatic logic [31:0] amux_fill(input int unsigned idx);
    return idx * 32'h0000_0123 + 32'h0000_3C5A;
  endfunction

  // Address word: length-1 in the top field, base address in the low field.
  function automatic logic [31:0] amux_addr_word(input int unsigned len_m1,
                                                 input int unsigned addr,
                                                 input int unsigned bus_w,
                                                 input int unsigned len_w);
    return (len_m1 << (bus_w - len_w)) | addr;
  endfunction

endpackage

// File: rtl/amux_arbiter.sv
module amux_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic gnt
);
  // Single requester: the grant follows the request one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt <= 1'b0;
    else        gnt <= req;
  end

  AST_GNT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gnt == $past(req)); // R2
endmodule

// File: rtl/amux_master.sv
module amux_master
  import amux_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int SETUP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len_m1,
  input  logic              gnt,
  input  logic              s_ack,
  input  logic              dready,
  input  logic [DATA_W-1:0] bus_in,
  output logic              req,
  output logic              read,
  output logic              m_ack,
  output logic              m_oe,
  output logic [DATA_W-1:0] m_bus,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  rd_index,
  output logic              done,
  output logic              busy
);
  localparam int SW = $clog2(SETUP + 2);

  mst_state_t        st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  word_q;
  logic [SW-1:0]     set_q;

  // Named internal events.
  logic word_taken, last_word, accept;
  assign accept     = (st == M_IDLE) && start;
  assign word_taken = (st == M_DWAIT) && dready;
  assign last_word  = (word_q == len_q);

  always_comb begin
    st_nx = st;
    unique case (st)
      M_IDLE:  if (start)   st_nx = M_REQ;
      M_REQ:   if (gnt)     st_nx = (SETUP == 0) ? M_ASTB : M_ASET;
      M_ASET:  if (set_q == SW'(SETUP - 1)) st_nx = M_ASTB;
      M_ASTB:  if (s_ack)   st_nx = M_AREL;
      M_AREL:  if (!s_ack)  st_nx = M_DWAIT;
      M_DWAIT: if (dready)  st_nx = M_DACK;
      M_DACK:  if (!dready) st_nx = last_word ? M_DONE : M_DWAIT;
      M_DONE:               st_nx = M_IDLE;
      default:              st_nx = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      addr_q   <= '0;
      len_q    <= '0;
      word_q   <= '0;
      set_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_index <= '0;
    end else begin
      st       <= st_nx;
      rd_valid <= word_taken;
      if (accept) begin
        addr_q <= start_addr;
        len_q  <= start_len_m1;
      end
      if (st == M_REQ)       set_q <= '0;
      else if (st == M_ASET) set_q <= set_q + 1'b1;
      if (st == M_AREL)                         word_q <= '0;
      else if ((st == M_DACK) && !dready)       word_q <= word_q + 1'b1;
      if (word_taken) begin
        rd_data  <= bus_in;
        rd_index <= word_q;
      end
    end
  end

  assign req   = (st != M_IDLE) && (st != M_DONE);
  assign read  = (st == M_ASTB);
  assign m_oe  = (st == M_ASET) || (st == M_ASTB);
  assign m_ack = (st == M_DACK);
  assign done  = (st == M_DONE);
  assign busy  = (st != M_IDLE);
  assign m_bus = DATA_W'(amux_addr_word(int'(len_q), int'(addr_q), DATA_W, LEN_W));

  AST_READ_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    read |-> gnt); // R2
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (read && !s_ack) |=> read); // R3
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && dready) |=> m_ack); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req); // R8
  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q) && $stable(addr_q)); // R9
endmodule

// File: rtl/amux_slave.sv
module amux_slave
  import amux_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int SETUP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              read,
  input  logic              m_ack,
  input  logic [DATA_W-1:0] bus_in,
  output logic              s_ack,
  output logic              dready,
  output logic              s_oe,
  output logic [DATA_W-1:0] s_bus
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SW    = $clog2(SETUP + 2);

  slv_state_t        st, st_nx;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  word_q;
  logic [SW-1:0]     set_q;
  logic [ADDR_W-1:0] idx;

  logic addr_latched, last_word;
  assign addr_latched = (st == S_IDLE) && read;
  assign last_word    = (word_q == len_q);
  assign idx          = base_q + ADDR_W'(word_q);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (read)   st_nx = S_AACK;
      S_AACK: if (!read)  st_nx = (SETUP == 0) ? S_DSTB : S_DSET;
      S_DSET: if (set_q == SW'(SETUP - 1)) st_nx = S_DSTB;
      S_DSTB: if (m_ack)  st_nx = S_DREL;
      S_DREL: if (!m_ack) st_nx = last_word ? S_IDLE :
                                  ((SETUP == 0) ? S_DSTB : S_DSET);
      default:            st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      len_q  <= '0;
      word_q <= '0;
      set_q  <= '0;
    end else begin
      st <= st_nx;
      if (addr_latched) begin
        base_q <= bus_in[ADDR_W-1:0];
        len_q  <= bus_in[DATA_W-1 -: LEN_W];
        word_q <= '0;
      end else if ((st == S_DREL) && !m_ack) begin
        word_q <= word_q + 1'b1;
      end
      if (st == S_DSET) set_q <= set_q + 1'b1;
      else              set_q <= '0;
    end
  end

  // Read-only word array, loaded at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(amux_fill(i));
    end
  end

  assign s_ack  = (st == S_AACK);
  assign dready = (st == S_DSTB);
  assign s_oe   = (st == S_DSET) || (st == S_DSTB);
  assign s_bus  = mem[idx];

  // Checker state: cycles the slave has driven before its strobe.
  logic [SW-1:0] drv_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       drv_run <= '0;
    else if (!s_oe)                   drv_run <= '0;
    else if (drv_run != SW'(SETUP))   drv_run <= drv_run + 1'b1;
  end

  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ack) |-> read); // R3
  AST_DRDY_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dready) |-> !m_ack); // R4
  AST_DRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dready && !m_ack) |=> dready); // R4
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dready) |-> drv_run == SW'(SETUP)); // R5
endmodule

// File: rtl/amux_read_link.sv
module amux_read_link
  import amux_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int SETUP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len_m1,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  rd_index,
  output logic              bus_req,
  output logic              bus_gnt,
  output logic [DATA_W-1:0] bus_ad,
  output logic              bus_m_oe,
  output logic              bus_s_oe,
  output logic              bus_read,
  output logic              bus_addr_ack,
  output logic              bus_dready,
  output logic              bus_data_ack,
  output logic              bus_err
);
  logic [DATA_W-1:0] m_bus, s_bus;

  amux_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .gnt(bus_gnt)
  );

  amux_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SETUP(SETUP)) u_mst (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len_m1(start_len_m1), .gnt(bus_gnt), .s_ack(bus_addr_ack),
    .dready(bus_dready), .bus_in(bus_ad), .req(bus_req), .read(bus_read),
    .m_ack(bus_data_ack), .m_oe(bus_m_oe), .m_bus(m_bus), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_index(rd_index), .done(done), .busy(busy)
  );

  amux_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .SETUP(SETUP)) u_slv (
    .clk(clk), .rst_n(rst_n), .read(bus_read), .m_ack(bus_data_ack),
    .bus_in(bus_ad), .s_ack(bus_addr_ack), .dready(bus_dready),
    .s_oe(bus_s_oe), .s_bus(s_bus)
  );

  // Shared lines: wired-OR of the gated drivers.
  assign bus_ad  = (bus_m_oe ? m_bus : '0) | (bus_s_oe ? s_bus : '0);
  assign bus_err = bus_m_oe && bus_s_oe;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_m_oe && bus_s_oe)); // R10
  AST_ADDR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |-> bus_m_oe); // R3
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_addr_ack) |-> !bus_read); // R3
endmodule

// File: tb/amux_read_link_bench.sv
module amux_read_link_bench;
  localparam int SETUP = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] start_addr = '0;
  logic [3:0] start_len_m1 = '0;
  logic busy, done, rd_valid, bus_req, bus_gnt, bus_m_oe, bus_s_oe;
  logic bus_read, bus_addr_ack, bus_dready, bus_data_ack, bus_err;
  logic [15:0] rd_data, bus_ad;
  logic [3:0] rd_index;

  always #4 clk = ~clk;

  amux_read_link #(.SETUP(SETUP)) u_amux_read_link (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len_m1(start_len_m1), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_index(rd_index), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_ad(bus_ad), .bus_m_oe(bus_m_oe), .bus_s_oe(bus_s_oe), .bus_read(bus_read),
    .bus_addr_ack(bus_addr_ack), .bus_dready(bus_dready),
    .bus_data_ack(bus_data_ack), .bus_err(bus_err)
  );

  int n_checks = 0, n_fail = 0;
  int cur_addr = 0, cur_len = 1;
  int words = 0, dr_cnt = 0, aphases = 0, m_run = 0, s_run = 0;
  bit done_seen = 1'b0;
  bit p_read, p_aack, p_dr, p_dack, p_done;

  function automatic int exp_word(int i);
    return (i * 291 + 15450) & 65535;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (addr=%0d len=%0d)", tag, act, exp, cur_addr, cur_len);
    end
  endtask

  // Monitor: samples at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      m_run = bus_m_oe ? m_run + 1 : 0;
      s_run = bus_s_oe ? s_run + 1 : 0;
      check(!bus_err && !(bus_m_oe && bus_s_oe), "R10", int'(bus_err), 0);
      if (bus_read && !p_read) begin
        check(bus_gnt, "R2", int'(bus_gnt), 1);
        check(bus_ad == 16'((cur_len - 1) * 4096 + cur_addr), "R3", int'(bus_ad), (cur_len - 1) * 4096 + cur_addr);
        check(m_run >= SETUP + 1, "R5", m_run, SETUP + 1);
        aphases++;
      end
      if (bus_addr_ack && !p_aack) check(bus_read, "R3", int'(bus_read), 1);
      if (!bus_read && p_read)     check(bus_addr_ack, "R3", int'(bus_addr_ack), 1);
      if (!bus_addr_ack && p_aack) check(!bus_read, "R3", int'(bus_read), 0);
      if (bus_dready && !p_dr) begin
        check(!bus_data_ack, "R4", int'(bus_data_ack), 0);
        check(int'(bus_ad) == exp_word((cur_addr + dr_cnt) % 64),
              (cur_addr + dr_cnt > 63) ? "R11" : "R6", int'(bus_ad), exp_word((cur_addr + dr_cnt) % 64));
        check(s_run >= SETUP + 1, "R5", s_run, SETUP + 1);
        dr_cnt++;
      end
      if (bus_data_ack && !p_dack) check(bus_dready, "R4", int'(bus_dready), 1);
      if (!bus_dready && p_dr)     check(bus_data_ack, "R4", int'(bus_data_ack), 1);
      if (!bus_data_ack && p_dack) check(!bus_dready, "R4", int'(bus_dready), 0);
      if (rd_valid) begin
        check(int'(rd_data) == exp_word((cur_addr + words) % 64),
              (cur_addr + words > 63) ? "R11" : "R6", int'(rd_data), exp_word((cur_addr + words) % 64));
        check(int'(rd_index) == words, "R6", int'(rd_index), words);
        words++;
      end
      if (p_done) begin
        check(!done, "R8", int'(done), 0);
        check(!busy, "R8", int'(busy), 0);
      end
      if (done) begin
        check(words == cur_len, "R7", words, cur_len);
        check(aphases == 1, "R7", aphases, 1);
        check(!bus_req && !bus_data_ack, "R8", int'(bus_req), 0);
        done_seen = 1'b1;
      end
      p_read = bus_read; p_aack = bus_addr_ack; p_dr = bus_dready;
      p_dack = bus_data_ack; p_done = done;
    end else begin
      p_read = 0; p_aack = 0; p_dr = 0; p_dack = 0; p_done = 0;
    end
  end

  task automatic run_xfer(int a, int l, bit poke);
    @(posedge clk); #2;
    cur_addr = a; cur_len = l + 1;
    words = 0; dr_cnt = 0; aphases = 0; done_seen = 1'b0;
    start = 1'b1; start_addr = 6'(a); start_len_m1 = 4'(l);
    @(posedge clk); #2;
    start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      #2;
      start = 1'b1; start_addr = 6'(a ^ 1); start_len_m1 = 4'(l ^ 3);
      @(posedge clk); #2;
      start = 1'b0;
    end
    while (!done_seen) @(posedge clk);
    #2;
    if (poke) begin
      repeat (3) @(posedge clk);
      #2;
      check(!busy && !bus_req, "R9", int'(busy), 0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_valid && !bus_req, "R1", int'(busy), 0);
    check(!bus_read && !bus_addr_ack && !bus_dready && !bus_data_ack, "R1", int'(bus_read), 0);
    check(!bus_m_oe && !bus_s_oe, "R1", int'(bus_m_oe), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !bus_req && !bus_m_oe, "R1", int'(busy), 0);
    for (int l = 0; l < 16; l++) begin
      for (int a = 0; a < 64; a++) begin
        run_xfer(a, l, (a % 9) == 4);
      end
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule